// File: doc/BRIEF.md
# DMA address translation map

This block sits between a 64/128-KB DMA or bus-master address space and a 26-bit physical memory space. It keeps a table of 16-bit physical page numbers, one per 1-KB page. Software fills the table through a small write/read port, usually several entries for one transfer, so that physical pages that lie scattered in memory look like one contiguous buffer to the DMA side.

Each cycle it can translate one address. A DMA request uses the transfer width to choose how it reads the address. Byte transfers take a 6-bit page index, so only the lower half of the table is used, and a full 10-bit offset. Word transfers take a 7-bit index and a word-aligned offset. When an external bus master owns the bus, any master address inside the low 512-KB window is translated in the same way as a byte-addressed access. The physical address appears on registered outputs one clock after the request.

Top module: `dma_xlat_map`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every table entry to 0. The edge after a reset cycle shows phys_vld=0, phys_addr=0, phys_mst=0 and cfg_rdata=0.
- R2: cfg_rdata is registered and shows the entry chosen by cfg_sel one clock later. When cfg_we is high, the entry at cfg_sel takes cfg_wdata, and cfg_rdata shows that new value on the next clock (write-first).
- R3: For a DMA request with dma_wide=0, the index is dma_addr[15:10], so dma_addr[16] is ignored. The result is phys_addr = {entry, dma_addr[9:0]}.
- R4: For a DMA request with dma_wide=1, the index is dma_addr[16:10]. The result is phys_addr = {entry, dma_addr[9:1], 0}, so phys_addr[0] is always 0.
- R5: When mst_own=1 and mst_addr < 0x80000, the index is mst_addr[16:10]. The result is phys_addr = {entry, mst_addr[9:0]} with phys_mst=1.
- R6: A master access with mst_own=0, or with mst_addr >= 0x80000, produces no translation: phys_vld=0 and phys_addr=0.
- R7: When a DMA request and a master window hit occur in the same cycle, the DMA request is translated and phys_mst=0.
- R8: The outputs follow the request cycle by exactly one clock. In a cycle with no request, the next clock shows phys_vld=0, phys_addr=0 and phys_mst=0.
- R9: A translation in the same cycle as a write to the entry it uses returns the entry value from before the write. The next translation returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 7 | Entry select for the write and the read |
| cfg_wdata | input | 16 | Page number to write |
| cfg_rdata | output | 16 | Registered read of the selected entry |
| dma_req | input | 1 | DMA translate request |
| dma_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit transfer |
| dma_addr | input | 17 | DMA-side address |
| mst_own | input | 1 | External bus master owns the bus |
| mst_addr | input | 24 | Bus-master address |
| phys_addr | output | 26 | Translated physical address |
| phys_vld | output | 1 | phys_addr holds a translation |
| phys_mst | output | 1 | 1 = the translation came from the master path |

## Verification
Two things can happen in the same cycle. The first is a table write and a translation that reads the same entry: the bench issues a word-wide DMA request that indexes the entry being written. The output must carry the page number from before the write, and the following cycle must carry the new one. The second is a DMA request together with a master window hit: the bench drives both in one cycle and expects the DMA result with the source flag low. A behavioural table model in the bench predicts every output and is compared with the design on each clock.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;

  typedef enum logic [0:0] {
    XL_SRC_DMA = 1'b0,
    XL_SRC_MST = 1'b1
  } xl_src_e;

endpackage

// File: rtl/dma_map_store.sv
module dma_map_store #(
  parameter int IDX_W  = 7,
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [PAGE_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [PAGE_W-1:0] lk_page
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [PAGE_W-1:0] page_tab [ENTRIES];

  // table write, cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) page_tab[e] <= '0;
    end else if (wr_en) begin
      page_tab[wr_sel] <= wr_data;
    end
  end

  // software read port: write-first when addressing the entry being written
  always_ff @(posedge clk) begin
    if (rst)                             rd_data <= '0;
    else if (wr_en && (wr_sel == rd_sel)) rd_data <= wr_data;
    else                                 rd_data <= page_tab[rd_sel];
  end

  // lookup sees the table contents before this cycle's write
  assign lk_page = page_tab[lk_idx];

  // R2
  wr_first_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel == rd_sel)) |=> (rd_data == $past(wr_data)));

endmodule

// File: rtl/dma_idx_sel.sv
module dma_idx_sel
  import dma_xlat_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int OFF_W = 10,
  parameter int MST_W = 24,
  parameter int WIN_W = 19
) (
  input  logic                   dma_req,
  input  logic                   dma_wide,
  input  logic [IDX_W+OFF_W-1:0] dma_addr,
  input  logic                   mst_own,
  input  logic [MST_W-1:0]       mst_addr,
  output logic                   hit,
  output xl_src_e                src,
  output logic [IDX_W-1:0]       idx,
  output logic [OFF_W-1:0]       off
);

  logic in_win;
  logic [IDX_W-1:0] dma_idx;
  logic [OFF_W-1:0] dma_off;

  assign in_win = mst_own && (mst_addr[MST_W-1:WIN_W] == '0);

  // byte transfers drop the top index bit, word transfers drop the offset LSB
  always_comb begin
    if (dma_wide) begin
      dma_idx = dma_addr[OFF_W +: IDX_W];
      dma_off = {dma_addr[OFF_W-1:1], 1'b0};
    end else begin
      dma_idx = {1'b0, dma_addr[OFF_W +: IDX_W-1]};
      dma_off = dma_addr[OFF_W-1:0];
    end
  end

  // DMA has priority over the master window
  always_comb begin
    hit = 1'b0;
    src = XL_SRC_DMA;
    idx = '0;
    off = '0;
    if (dma_req) begin
      hit = 1'b1;
      idx = dma_idx;
      off = dma_off;
    end else if (in_win) begin
      hit = 1'b1;
      src = XL_SRC_MST;
      idx = mst_addr[OFF_W +: IDX_W];
      off = mst_addr[OFF_W-1:0];
    end
  end

endmodule

// File: rtl/dma_pa_join.sv
module dma_pa_join
  import dma_xlat_pkg::*;
#(
  parameter int PAGE_W = 16,
  parameter int OFF_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hit,
  input  xl_src_e                 src,
  input  logic [PAGE_W-1:0]       page,
  input  logic [OFF_W-1:0]        off,
  output logic [PAGE_W+OFF_W-1:0] phys_addr,
  output logic                    phys_vld,
  output logic                    phys_mst
);

  always_ff @(posedge clk) begin
    if (rst || !hit) begin
      phys_addr <= '0;
      phys_vld  <= 1'b0;
      phys_mst  <= 1'b0;
    end else begin
      phys_addr <= {page, off};
      phys_vld  <= 1'b1;
      phys_mst  <= (src == XL_SRC_MST);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!phys_vld && (phys_addr == '0) && !phys_mst));

endmodule

// File: rtl/dma_xlat_map.sv
module dma_xlat_map
  import dma_xlat_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int OFF_W  = 10,
  parameter int PAGE_W = 16,
  parameter int MST_W  = 24,
  parameter int WIN_W  = 19
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_sel,
  input  logic [PAGE_W-1:0]       cfg_wdata,
  output logic [PAGE_W-1:0]       cfg_rdata,
  input  logic                    dma_req,
  input  logic                    dma_wide,
  input  logic [IDX_W+OFF_W-1:0]  dma_addr,
  input  logic                    mst_own,
  input  logic [MST_W-1:0]        mst_addr,
  output logic [PAGE_W+OFF_W-1:0] phys_addr,
  output logic                    phys_vld,
  output logic                    phys_mst
);

  logic              lk_hit;
  xl_src_e           lk_src;
  logic [IDX_W-1:0]  lk_idx;
  logic [OFF_W-1:0]  lk_off;
  logic [PAGE_W-1:0] lk_page;

  dma_map_store #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) i_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .rd_sel  (cfg_sel),
    .rd_data (cfg_rdata),
    .lk_idx  (lk_idx),
    .lk_page (lk_page)
  );

  dma_idx_sel #(.IDX_W(IDX_W), .OFF_W(OFF_W), .MST_W(MST_W), .WIN_W(WIN_W)) i_sel (
    .dma_req  (dma_req),
    .dma_wide (dma_wide),
    .dma_addr (dma_addr),
    .mst_own  (mst_own),
    .mst_addr (mst_addr),
    .hit      (lk_hit),
    .src      (lk_src),
    .idx      (lk_idx),
    .off      (lk_off)
  );

  dma_pa_join #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) i_join (
    .clk       (clk),
    .rst       (rst),
    .hit       (lk_hit),
    .src       (lk_src),
    .page      (lk_page),
    .off       (lk_off),
    .phys_addr (phys_addr),
    .phys_vld  (phys_vld),
    .phys_mst  (phys_mst)
  );

  // R4
  wide_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dma_wide) |=> (phys_vld && !phys_addr[0]));

  // R7
  dma_first_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> (phys_vld && !phys_mst));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!dma_req && (!mst_own || (mst_addr[MST_W-1:WIN_W] != '0)))
      |=> (!phys_vld && (phys_addr == '0)));

  // R5
  mst_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!dma_req && mst_own && (mst_addr[MST_W-1:WIN_W] == '0)) |=> (phys_vld && phys_mst));

endmodule

// File: tb/test_dma_xlat_map.sv
module test_dma_xlat_map;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        dma_req = 1'b0;
  logic        dma_wide = 1'b0;
  logic [16:0] dma_addr = '0;
  logic        mst_own = 1'b0;
  logic [23:0] mst_addr = '0;
  logic [25:0] phys_addr;
  logic        phys_vld;
  logic        phys_mst;

  always #5 clk = ~clk;

  dma_xlat_map i_dma_xlat_map (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_req(dma_req),
    .dma_wide(dma_wide), .dma_addr(dma_addr), .mst_own(mst_own),
    .mst_addr(mst_addr), .phys_addr(phys_addr), .phys_vld(phys_vld),
    .phys_mst(phys_mst)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  int    model [128];
  int    exp_pa = 0;
  bit    exp_vld = 1'b0;
  bit    exp_mst = 1'b0;
  int    exp_rd = 0;
  string xl_tag = "R1";
  string rd_tag = "R1";

  function automatic int pat(input int i);
    return ((i * 'h3b29) ^ 'hc35a) & 'hFFFF;
  endfunction

  task automatic check_out();
    total += 2;
    if (phys_vld !== exp_vld || phys_mst !== exp_mst || phys_addr !== exp_pa[25:0]) begin
      bad++;
      $display("FAIL %s: vld=%0b mst=%0b pa=%h expected vld=%0b mst=%0b pa=%h",
               xl_tag, phys_vld, phys_mst, phys_addr, exp_vld, exp_mst, exp_pa[25:0]);
    end
    if (cfg_rdata !== exp_rd[15:0]) begin
      bad++;
      $display("FAIL %s: rdata=%h expected %h", rd_tag, cfg_rdata, exp_rd[15:0]);
    end
  endtask

  task automatic step(input bit r, input bit we, input int sel, input int wd,
                      input bit dq, input bit dw, input int da,
                      input bit mo, input int ma, input string tag);
    bit win;
    int ix;
    @(negedge clk);
    check_out();
    rst = r; cfg_we = we; cfg_sel = sel[6:0]; cfg_wdata = wd[15:0];
    dma_req = dq; dma_wide = dw; dma_addr = da[16:0];
    mst_own = mo; mst_addr = ma[23:0];
    win = mo && (ma < 'h80000);
    if (r) begin
      foreach (model[k]) model[k] = 0;
      exp_vld = 0; exp_mst = 0; exp_pa = 0; exp_rd = 0;
      xl_tag = "R1"; rd_tag = "R1";
    end else begin
      exp_rd = we ? (wd & 'hFFFF) : model[sel & 127];
      rd_tag = "R2";
      if (dq) begin
        ix = dw ? ((da >> 10) & 127) : ((da >> 10) & 63);
        exp_pa = model[ix] * 1024 + (dw ? (da & 1022) : (da & 1023));
        exp_vld = 1; exp_mst = 0;
        xl_tag = win ? "R7" : (dw ? "R4" : "R3");
      end else if (win) begin
        ix = (ma >> 10) & 127;
        exp_pa = model[ix] * 1024 + (ma & 1023);
        exp_vld = 1; exp_mst = 1;
        xl_tag = "R5";
      end else begin
        exp_pa = 0; exp_vld = 0; exp_mst = 0;
        xl_tag = (mo || ma != 0) ? "R6" : "R8";
      end
      if (tag != "") xl_tag = tag;
      if (we) model[sel & 127] = wd & 'hFFFF;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (model[k]) model[k] = 0;
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R1: entries read as zero right after reset
    step(0, 0, 77, 0, 1, 0, 'h0C2A5, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 1, 'h1F3FF, "R1");
    // R2: fill the table, read back write-first
    for (int i = 0; i < 128; i++) step(0, 1, i, pat(i), 0, 0, 0, 0, 0, "");
    for (int i = 0; i < 128; i += 9) step(0, 0, i, 0, 0, 0, 0, 0, 0, "");
    // R3: byte transfers, bit 16 toggled and ignored
    for (int k = 0; k < 24; k++)
      step(0, 0, k, 0, 1, 0, ((k * 4099) + ((k % 2) * 'h10000)) & 'h1FFFF, 0, 0, "");
    // R4: word transfers over the full index range
    for (int k = 0; k < 24; k++)
      step(0, 0, k, 0, 1, 1, (k * 5471 + 3) & 'h1FFFF, 0, 0, "");
    // R5: master inside the window, incl. top of window
    for (int k = 0; k < 16; k++)
      step(0, 0, 0, 0, 0, 0, 0, 1, (k * 13001) & 'h7FFFF, "");
    step(0, 0, 0, 0, 0, 0, 0, 1, 'h7FFFF, "");
    // R6: outside the window, or master not owning the bus
    step(0, 0, 0, 0, 0, 0, 0, 1, 'h80000, "");
    for (int k = 0; k < 8; k++)
      step(0, 0, 0, 0, 0, 0, 0, 1, 'h80000 + k * 'h31777, "");
    step(0, 0, 0, 0, 0, 0, 0, 0, 'h12345, "");
    // R7: DMA and master window hit together
    for (int k = 0; k < 6; k++)
      step(0, 0, 0, 0, 1, k % 2, k * 9001, 1, 'h40000 + k * 777, "");
    // R8: idle cycles after activity
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    // R9: write and translate the same entry in one cycle
    step(0, 1, 5, 'hBEEF, 1, 1, (5 << 10) | 'h2F7, 0, 0, "R9");
    step(0, 0, 5, 0, 1, 1, (5 << 10) | 'h2F7, 0, 0, "R9");
    step(0, 1, 100, 'h0123, 0, 0, 0, 1, (100 << 10) | 'h155, "R9");
    step(0, 0, 100, 0, 0, 0, 0, 1, (100 << 10) | 'h155, "R9");
    // R1: reset in mid-run clears the table
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 100, 0, 1, 1, (100 << 10) | 'h3FE, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    @(negedge clk);
    check_out();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule